// File: doc/BRIEF.md
# Trace Capture Ring Buffer

This block stores one wide trace word on every clock edge into an on-chip RAM that is used as a circular buffer. The newest entries overwrite the oldest once the buffer has filled. It keeps a history of the last few thousand cycles of whatever state the surrounding logic routes into `trace_in`. That history can then be inspected after an event of interest.

Two independent register ports read the buffer back: one for the processor's special-register path and one for the debug path. Each port has a 64-bit address register and a 64-bit data port. The upper word of the address register shows the current write position, with the buffer depth ORed in, so software can find the depth from the position of the highest set bit. The lower word holds that port's own read pointer, counted in 64-bit doublewords, and a freeze bit. Each data request returns one doubleword one cycle later and moves the pointer forward.

Capture stops while either port holds its freeze bit, so the contents stay still while they are read out.

Top module: `trace_ring_log`

## Requirements
- R1: While reset is asserted, both address registers read `{DEPTH, 32'h0}`: the write position is 0, both read pointers and freeze bits are 0, and neither data-valid output is set.
- R2: On every clock edge when neither freeze bit is set, `trace_in` is stored at the write position, and the position then advances by one entry, wrapping from DEPTH-1 to 0.
- R3: Bits 63:32 of each address register equal DEPTH OR the write position, counted in whole entries. Both ports report the same value.
- R4: Bit 31 of an address register is that port's freeze bit. Bits 30:0 are its read pointer, counted in 64-bit doublewords.
- R5: A data request returns, on the next cycle with data-valid set, doubleword k of entry e. Here k is read pointer bits 1:0, e is the remaining pointer bits modulo DEPTH, and doubleword k is entry bits 64k+63:64k. With no request in the previous cycle, data-valid is 0 and the data output is 0.
- R6: Each data request without a same-cycle address write advances that port's read pointer by exactly one doubleword. Reads past the end of the buffer wrap around to entry 0.
- R7: A write to an address register loads the read pointer from write-data bits 30:0 and the freeze bit from bit 31. Bits 63:32 of the write data are ignored and leave the write position unchanged. When a port writes its address register and requests data in the same cycle, the write wins.
- R8: Capture is frozen while either freeze bit is set, or both are set. It resumes only once both are clear.
- R9: Requests and address writes on one port never change the other port's read pointer or freeze bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trace_in | input | ENTRY_W | Trace word captured each unfrozen cycle |
| cpu_addr_we | input | 1 | Write strobe for the special-register port's address register |
| cpu_addr_wdata | input | 64 | Write data for that address register |
| cpu_addr_rdata | output | 64 | Current address register value, special-register port |
| cpu_data_req | input | 1 | Request one doubleword on the special-register port |
| cpu_data_out | output | 64 | Returned doubleword, special-register port |
| cpu_data_vld | output | 1 | cpu_data_out holds a result |
| dbg_addr_we | input | 1 | Write strobe for the debug port's address register |
| dbg_addr_wdata | input | 64 | Write data for that address register |
| dbg_addr_rdata | output | 64 | Current address register value, debug port |
| dbg_data_req | input | 1 | Request one doubleword on the debug port |
| dbg_data_out | output | 64 | Returned doubleword, debug port |
| dbg_data_vld | output | 1 | dbg_data_out holds a result |

## Verification
The trace input carries a per-cycle stamp in every doubleword, together with that doubleword's own lane number. A value read back therefore shows both which cycle was captured and which quarter of the entry was picked. Readouts are made with capture frozen by each port in turn and then by both ports. This separates a freeze bit that is wired to only one port from the proper OR of the two. One port's pointer is set just below four times the depth, so that its reads cross the end of the buffer. A short burst of reads is also taken while capture runs, which fixes that a read on the same edge as a write returns the entry's older contents. A full sweep after a wrap of the write position shows that every entry was overwritten in order.

// File: rtl/trace_log_pkg.sv
package trace_log_pkg;
    // Register-level constants shared by every part of the trace buffer
    localparam int REG_W  = 64;   // width of address and data registers
    localparam int DW_W   = 64;   // one readout doubleword
    localparam int HALF_W = 32;   // upper/lower halves of the address register
    localparam int PTR_W  = 31;   // read pointer width, bit 31 is the freeze bit
endpackage

// File: rtl/trace_log_wrptr.sv
module trace_log_wrptr #(
    parameter int DEPTH = 2048
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     freeze,
    output logic                     wr_en,
    output logic [$clog2(DEPTH)-1:0] wr_ptr
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] ptr;
    } wp_state_t;

    wp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!freeze) begin
            // power-of-two depth: natural overflow gives the wrap
            st_d.ptr = st_q.ptr + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en  = !freeze;
    assign wr_ptr = st_q.ptr;

    AST_WP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(wr_ptr)); // R8

    AST_WP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze |=> (wr_ptr == AW'($past(wr_ptr) + AW'(1)))); // R2

endmodule

// File: rtl/trace_log_ram.sv
module trace_log_ram #(
    parameter int ENTRY_W = 256,
    parameter int DEPTH   = 2048,
    parameter int NRD     = 2
) (
    input  logic                               clk,
    input  logic                               we,
    input  logic [$clog2(DEPTH)-1:0]           waddr,
    input  logic [ENTRY_W-1:0]                 wdata,
    input  logic [NRD-1:0]                     re,
    input  logic [NRD-1:0][$clog2(DEPTH)-1:0]  raddr,
    output logic [NRD-1:0][ENTRY_W-1:0]        rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [ENTRY_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // One registered read port per reader; a same-edge write is not seen
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        logic [ENTRY_W-1:0] rd_q;
        always_ff @(posedge clk) begin
            if (re[g]) begin
                rd_q <= mem[raddr[g]];
            end
        end
        assign rdata[g] = rd_q;
    end

endmodule

// File: rtl/trace_log_port.sv
module trace_log_port
    import trace_log_pkg::*;
#(
    parameter int ENTRY_W = 256,
    parameter int DEPTH   = 2048
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     addr_we,
    input  logic [REG_W-1:0]         addr_wdata,
    input  logic                     data_req,
    input  logic [$clog2(DEPTH)-1:0] wr_ptr,
    input  logic [ENTRY_W-1:0]       ram_rdata,
    output logic [REG_W-1:0]         addr_rdata,
    output logic                     freeze,
    output logic                     ram_re,
    output logic [$clog2(DEPTH)-1:0] ram_raddr,
    output logic [DW_W-1:0]          data_out,
    output logic                     data_vld
);
    localparam int AW    = $clog2(DEPTH);
    localparam int NDW   = ENTRY_W / DW_W;
    localparam int SEL_W = (NDW > 1) ? $clog2(NDW) : 1;
    localparam int SEL_USED = $clog2(NDW);

    typedef struct packed {
        logic [PTR_W-1:0] rd_ptr;
        logic             frz;
        logic [SEL_W-1:0] sel;
        logic             vld;
    } port_state_t;

    port_state_t st_d, st_q;

    logic [NDW-1:0][DW_W-1:0] dw_view;
    logic [HALF_W-1:0]        wp_word;
    logic                     unused_hi;

    always_comb begin
        st_d     = st_q;
        st_d.vld = data_req;
        if (data_req) begin
            st_d.sel    = SEL_W'(st_q.rd_ptr[SEL_W-1:0]);
            st_d.rd_ptr = st_q.rd_ptr + PTR_W'(1);
        end
        if (addr_we) begin
            st_d.rd_ptr = addr_wdata[PTR_W-1:0];
            st_d.frz    = addr_wdata[PTR_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Entry index = pointer bits above the doubleword lane, modulo DEPTH
    assign ram_re    = data_req;
    assign ram_raddr = st_q.rd_ptr[SEL_USED +: AW];

    assign dw_view  = ram_rdata;
    assign data_out = st_q.vld ? dw_view[st_q.sel] : '0;
    assign data_vld = st_q.vld;

    // Depth is a power of two, so OR places a single marker bit above the pointer
    assign wp_word    = HALF_W'(DEPTH) | HALF_W'(wr_ptr);
    assign addr_rdata = {wp_word, st_q.frz, st_q.rd_ptr};
    assign freeze     = st_q.frz;
    assign unused_hi  = ^addr_wdata[REG_W-1:HALF_W];

    AST_RP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_req && !addr_we) |=> (addr_rdata[PTR_W-1:0] == PTR_W'($past(addr_rdata[PTR_W-1:0]) + PTR_W'(1)))); // R6

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        addr_we |=> ((freeze == $past(addr_wdata[PTR_W])) && (addr_rdata[PTR_W-1:0] == $past(addr_wdata[PTR_W-1:0])))); // R7

    AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_we && !data_req) |=> ($stable(addr_rdata[HALF_W-1:0]))); // R4

    AST_VLD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        data_req |=> data_vld); // R5

    AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !data_req |=> (!data_vld && (data_out == '0))); // R5

endmodule

// File: rtl/trace_ring_log.sv
module trace_ring_log
    import trace_log_pkg::*;
#(
    parameter int ENTRY_W = 256,
    parameter int DEPTH   = 2048
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRY_W-1:0] trace_in,
    input  logic               cpu_addr_we,
    input  logic [REG_W-1:0]   cpu_addr_wdata,
    output logic [REG_W-1:0]   cpu_addr_rdata,
    input  logic               cpu_data_req,
    output logic [DW_W-1:0]    cpu_data_out,
    output logic               cpu_data_vld,
    input  logic               dbg_addr_we,
    input  logic [REG_W-1:0]   dbg_addr_wdata,
    output logic [REG_W-1:0]   dbg_addr_rdata,
    input  logic               dbg_data_req,
    output logic [DW_W-1:0]    dbg_data_out,
    output logic               dbg_data_vld
);
    localparam int AW     = $clog2(DEPTH);
    localparam int NPORT  = 2;
    localparam int P_CPU  = 0;
    localparam int P_DBG  = 1;

    logic [NPORT-1:0]              p_we, p_req, p_frz, p_re, p_vld;
    logic [NPORT-1:0][REG_W-1:0]   p_wdata, p_rdata;
    logic [NPORT-1:0][DW_W-1:0]    p_dout;
    logic [NPORT-1:0][AW-1:0]      p_raddr;
    logic [NPORT-1:0][ENTRY_W-1:0] p_ram;

    logic          freeze_any;
    logic          wr_en;
    logic [AW-1:0] wr_ptr;

    assign p_we[P_CPU]    = cpu_addr_we;
    assign p_we[P_DBG]    = dbg_addr_we;
    assign p_req[P_CPU]   = cpu_data_req;
    assign p_req[P_DBG]   = dbg_data_req;
    assign p_wdata[P_CPU] = cpu_addr_wdata;
    assign p_wdata[P_DBG] = dbg_addr_wdata;

    assign cpu_addr_rdata = p_rdata[P_CPU];
    assign dbg_addr_rdata = p_rdata[P_DBG];
    assign cpu_data_out   = p_dout[P_CPU];
    assign dbg_data_out   = p_dout[P_DBG];
    assign cpu_data_vld   = p_vld[P_CPU];
    assign dbg_data_vld   = p_vld[P_DBG];

    // Either port's freeze bit halts capture
    assign freeze_any = |p_frz;

    trace_log_wrptr #(
        .DEPTH (DEPTH)
    ) u_wrptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (freeze_any),
        .wr_en  (wr_en),
        .wr_ptr (wr_ptr)
    );

    trace_log_ram #(
        .ENTRY_W (ENTRY_W),
        .DEPTH   (DEPTH),
        .NRD     (NPORT)
    ) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_ptr),
        .wdata (trace_in),
        .re    (p_re),
        .raddr (p_raddr),
        .rdata (p_ram)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        trace_log_port #(
            .ENTRY_W (ENTRY_W),
            .DEPTH   (DEPTH)
        ) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .addr_we    (p_we[g]),
            .addr_wdata (p_wdata[g]),
            .data_req   (p_req[g]),
            .wr_ptr     (wr_ptr),
            .ram_rdata  (p_ram[g]),
            .addr_rdata (p_rdata[g]),
            .freeze     (p_frz[g]),
            .ram_re     (p_re[g]),
            .ram_raddr  (p_raddr[g]),
            .data_out   (p_dout[g]),
            .data_vld   (p_vld[g])
        );
    end

    AST_WP_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr_rdata[REG_W-1:HALF_W] == dbg_addr_rdata[REG_W-1:HALF_W]); // R3

    AST_FRZ_EITHER: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr_rdata[PTR_W] || dbg_addr_rdata[PTR_W]) |=> $stable(cpu_addr_rdata[REG_W-1:HALF_W])); // R8

    AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_addr_we && !dbg_data_req) |=> $stable(dbg_addr_rdata[HALF_W-1:0])); // R9

endmodule

// File: tb/trace_ring_log_tb.sv
module trace_ring_log_tb;
    localparam int TB_EW    = 256;
    localparam int TB_DEPTH = 16;
    localparam int TB_NDW   = TB_EW / 64;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [TB_EW-1:0]   trace_in = '0;
    logic               we   [2];
    logic [63:0]        wdat [2];
    logic               req  [2];
    logic [63:0]        ardat[2];
    logic [63:0]        dout [2];
    logic               vld  [2];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int stamp = 0;

    // reference model state
    logic [TB_EW-1:0] m_mem [TB_DEPTH];
    int               m_wp;
    logic             m_frz [2];
    logic [30:0]      m_rp  [2];
    logic [63:0]      exp_q [2][$];

    always #10 clk = ~clk; // 50 MHz

    trace_ring_log #(.ENTRY_W(TB_EW), .DEPTH(TB_DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .trace_in(trace_in),
        .cpu_addr_we(we[0]), .cpu_addr_wdata(wdat[0]), .cpu_addr_rdata(ardat[0]),
        .cpu_data_req(req[0]), .cpu_data_out(dout[0]), .cpu_data_vld(vld[0]),
        .dbg_addr_we(we[1]), .dbg_addr_wdata(wdat[1]), .dbg_addr_rdata(ardat[1]),
        .dbg_data_req(req[1]), .dbg_data_out(dout[1]), .dbg_data_vld(vld[1])
    );

    function automatic logic [TB_EW-1:0] mk_trace(int s);
        logic [TB_EW-1:0] t;
        for (int k = 0; k < TB_NDW; k++) t[k*64 +: 64] = {32'hC0DE_0000 + 32'(k), 32'(s)};
        return t;
    endfunction

    // model: mirrors the requirements on every edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_wp = 0;
            for (int p = 0; p < 2; p++) begin m_frz[p] = 0; m_rp[p] = '0; end
        end else begin
            if (!(m_frz[0] || m_frz[1])) begin          // R2, R8
                m_mem[m_wp] = trace_in;
                m_wp = (m_wp + 1) % TB_DEPTH;
            end
            for (int p = 0; p < 2; p++) begin
                if (we[p]) begin m_rp[p] = wdat[p][30:0]; m_frz[p] = wdat[p][31]; end // R7
                else if (req[p]) m_rp[p] = m_rp[p] + 31'd1;                           // R6
            end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected doublewords as results appear
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < 2; p++) begin
                if (vld[p]) begin
                    if (exp_q[p].size() == 0) chk("R5 unexpected valid", 64'(p), 64'hFFFF);
                    else chk("R5 readout data", dout[p], exp_q[p].pop_front());
                end
            end
        end
    end

    task automatic wr_addr(int p, logic [63:0] v);
        we[p] = 1'b1; wdat[p] = v;
        @(negedge clk);
        we[p] = 1'b0; wdat[p] = '0;
    endtask

    // driver: pushes the model's doubleword at the current read pointer
    task automatic rd(int p);
        int e;
        int k;
        e = int'(m_rp[p] >> 2) % TB_DEPTH;
        k = int'(m_rp[p][1:0]);
        exp_q[p].push_back(m_mem[e][k*64 +: 64]);
        req[p] = 1'b1;
        @(negedge clk);
        req[p] = 1'b0;
    endtask

    function automatic logic [31:0] wp_word();
        return 32'(TB_DEPTH) | 32'(m_wp);
    endfunction

    always @(negedge clk) begin
        stamp <= stamp + 1;
        trace_in <= mk_trace(stamp + 1);
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] held;
        for (int p = 0; p < 2; p++) begin we[p] = 0; wdat[p] = '0; req[p] = 0; end
        repeat (2) @(negedge clk);
        // R1: reset state
        for (int p = 0; p < 2; p++) begin
            chk("R1 addr reg in reset", ardat[p], {32'(TB_DEPTH), 32'h0});
            chk("R1 valid in reset", 64'(vld[p]), 64'h0);
        end
        rst_n = 1'b1;
        // run past one full wrap so every entry is written (R2)
        repeat (TB_DEPTH + 5) @(negedge clk);
        chk("R3 write word running", 64'(ardat[0][63:32]), 64'(wp_word()));

        // freeze from the cpu port only
        wr_addr(0, 64'h0000_0000_8000_0000);
        held = ardat[0][63:32];
        chk("R3 write word frozen", 64'(held), 64'(wp_word()));
        chk("R4 freeze bit and pointer", 64'(ardat[0][31:0]), 64'h8000_0000);
        repeat (4) @(negedge clk);
        chk("R8 cpu freeze holds position", 64'(ardat[0][63:32]), 64'(held));
        chk("R3 both ports agree", 64'(ardat[1][63:32]), 64'(held));

        // R5: eight sequential doublewords
        for (int i = 0; i < 8; i++) rd(0);
        @(negedge clk);
        chk("R6 pointer after 8 reads", 64'(ardat[0][31:0]), 64'h8000_0008);

        // R6 wrap on the debug port, R9 independence
        wr_addr(1, 64'(4 * TB_DEPTH - 2));
        for (int i = 0; i < 4; i++) rd(1);
        @(negedge clk);
        chk("R6 debug pointer past end", 64'(ardat[1][31:0]), 64'(4 * TB_DEPTH + 2));
        chk("R9 cpu pointer untouched", 64'(ardat[0][31:0]), 64'h8000_0008);

        // R8: debug freezes, cpu releases: still frozen
        wr_addr(1, 64'h0000_0000_8000_0000);
        wr_addr(0, 64'hFFFF_FFFF_0000_0003);
        chk("R7 upper write bits ignored", 64'(ardat[0][63:32]), 64'(held));
        chk("R7 pointer loaded", 64'(ardat[0][31:0]), 64'h0000_0003);
        repeat (3) @(negedge clk);
        chk("R8 debug freeze holds position", 64'(ardat[1][63:32]), 64'(held));

        // both clear: capture resumes
        wr_addr(1, 64'h0);
        repeat (7) @(negedge clk);
        chk("R2 capture resumed", 64'(ardat[0][63:32]), 64'(wp_word()));
        if (ardat[0][63:32] == held) chk("R8 position moved", 64'(ardat[0][63:32]), 64'(held) + 64'd1);

        // R5: reads while capture is running
        for (int i = 0; i < 4; i++) rd(0);

        // R7: address write wins over same-cycle request
        we[0] = 1'b1; wdat[0] = 64'h0000_0000_0000_0020; req[0] = 1'b1;
        exp_q[0].push_back(m_mem[int'(m_rp[0] >> 2) % TB_DEPTH][int'(m_rp[0][1:0])*64 +: 64]);
        @(negedge clk);
        we[0] = 1'b0; wdat[0] = '0; req[0] = 1'b0;
        chk("R7 write beats request", 64'(ardat[0][31:0]), 64'h0000_0020);

        // freeze via debug, sweep the whole buffer on the cpu port
        wr_addr(1, 64'h0000_0000_8000_0000);
        wr_addr(0, 64'h0);
        for (int i = 0; i < 4 * TB_DEPTH; i++) rd(0);
        @(negedge clk);
        @(negedge clk);
        chk("R5 idle valid low", 64'(vld[0]), 64'h0);
        chk("R5 idle data zero", dout[0], 64'h0);
        chk("R5 queue drained", 64'(exp_q[0].size() + exp_q[1].size()), 64'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule